// File: doc/BRIEF.md
# Selectable Three-Chain Parallel Word Loader

This block loads display and calibration words into a driver through one 10-bit parallel port. A two-bit select input chooses one of three word chains: grayscale, brightness, or dot correction. On each active edge of a data clock, the chosen chain takes the input word at its head. Every other word moves one place along, and the oldest word drops off the tail. The tail word of the chosen chain is always shown on a 10-bit cascade output, so several devices can be wired in series and loaded as one long chain.

The data clock is sampled by the system clock. A polarity input picks which data-clock edge counts: high selects rising edges, low selects falling edges. Each chain has a latch bank that is separate from the chain, and a strobe copies the chosen chain into its own bank. The brightness bank and the dot-correction bank each have an enable input. While that enable is low, the bank is held at its full-scale default, so the driver runs at 100% whatever is written.

Top module: `word_loader`

## Requirements
- R1: Synchronous reset, active high, clears every chain word to zero and the grayscale latch to zero. It sets every brightness and dot-correction latch word to full scale (all ones), and the cascade output reads zero afterwards.
- R2: When the polarity input is high, each rising edge of the data clock shifts the selected chain by one word. The chain changes at the first system clock edge that sees the new data-clock level. Falling edges shift nothing.
- R3: When the polarity input is low, each falling edge of the data clock shifts the selected chain, and rising edges shift nothing.
- R4: The cascade output shows the tail word of the selected chain. A word that enters a chain of depth CH reaches the output after CH active edges, and the output changes at once when the select input changes.
- R5: Select code 0 picks the grayscale chain, code 1 the brightness chain, and code 2 the dot-correction chain. Chains that are not selected keep their contents across active edges.
- R6: Select code 3 shifts no chain, and the cascade output reads zero while it is applied.
- R7: While the brightness enable is low, every brightness latch word reads full scale from the next system clock edge on.
- R8: While the dot-correction enable is low, every dot-correction latch word reads full scale from the next system clock edge on.
- R9: A latch strobe copies every word of the selected chain into that chain's latch bank at the next system clock edge. Latch word k comes from chain word k, and word 0 is the newest word. The grayscale bank always accepts the strobe. The other two banks accept it only while their enable is high.
- R10: A strobe aimed at the brightness or dot-correction bank while its enable is low leaves that bank at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Data clock, sampled by clk |
| sclk_pol | input | 1 | Active data-clock edge: 1 rising, 0 falling |
| chain_sel | input | 2 | Chain select: 0 grayscale, 1 brightness, 2 dot correction, 3 none |
| din | input | 10 | Parallel word entering the head of the selected chain |
| dout | output | 10 | Tail word of the selected chain, for cascading |
| bc_enable | input | 1 | Brightness latch enable; low forces full scale |
| dc_enable | input | 1 | Dot-correction latch enable; low forces full scale |
| latch_stb | input | 1 | Copies the selected chain into its latch bank |
| gs_latched | output | CH*10 | Grayscale latch words, word k at bits [10k+9:10k] |
| bc_latched | output | CH*10 | Brightness latch words, same layout |
| dc_latched | output | CH*10 | Dot-correction latch words, same layout |

## Verification
Any wrong word in a chain shows up at the cascade output CH active edges later, or at once in a latch bank the next time a strobe copies that chain. A shift on the wrong edge, or a shift of the wrong chain, changes the selected tail within one system clock. Every unselected chain is later brought out through the select input and checked. A bank that is not forced to its default, or that is wrongly written, differs on the latch outputs one system clock after the enable or the strobe. For this reason the bench compares the cascade output and all three latch banks against a queue model on every clock.

// File: rtl/word_loader_pkg.sv
package word_loader_pkg;

    localparam int WORD_W   = 10;
    localparam int N_CHAINS = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_GRAY   = 2'd0,
        SEL_BRIGHT = 2'd1,
        SEL_DOTCOR = 2'd2,
        SEL_NONE   = 2'd3
    } chain_sel_e;

    // Value a latch bank takes at reset and while its enable is low.
    function automatic word_t bank_default(input int idx);
        return (idx == 0) ? word_t'(0) : '1;
    endfunction

endpackage

// File: rtl/word_loader_edge.sv
module word_loader_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic pol,
    output logic active
);
    logic sclk_q;

    // Follows sclk during reset too, so no edge appears at reset release.
    always_ff @(posedge clk) begin
        sclk_q <= sclk;
    end

    assign active = !rst && (sclk != sclk_q) && (sclk == pol);

    // R2 / R3: an accepted edge always lands on the level that the polarity asks for.
    assert_edge_level_R2: assert property (@(posedge clk) disable iff (rst)
        active |-> (sclk == pol) && (sclk != $past(sclk)));

endmodule

// File: rtl/word_loader_chain.sv
module word_loader_chain
    import word_loader_pkg::*;
#(
    parameter int CH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  shift,
    input  word_t din,
    output word_t words [CH]
);
    word_t regs [CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < CH; k++) regs[k] <= '0;
        end else if (shift) begin
            regs[0] <= din;
            for (int k = 1; k < CH; k++) regs[k] <= regs[k-1];
        end
    end

    assign words = regs;

    // R2: the head word takes the input word on a shift.
    assert_head_load_R2: assert property (@(posedge clk) disable iff (rst)
        shift |=> regs[0] == $past(din));

    generate
        for (genvar k = 0; k < CH; k++) begin : g_hold
            // R5: a chain that is not shifted keeps every word.
            assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
                !shift |=> $stable(regs[k]));
        end
    endgenerate

endmodule

// File: rtl/word_loader_bank.sv
module word_loader_bank
    import word_loader_pkg::*;
#(
    parameter int    CH      = 16,
    parameter word_t DEF_VAL = '1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  strobe,
    input  word_t src [CH],
    output word_t lat [CH]
);
    word_t regs [CH];

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            for (int k = 0; k < CH; k++) regs[k] <= DEF_VAL;
        end else if (strobe) begin
            for (int k = 0; k < CH; k++) regs[k] <= src[k];
        end
    end

    assign lat = regs;

    generate
        for (genvar k = 0; k < CH; k++) begin : g_chk
            // R7 / R8 / R10: a disabled bank reads its default.
            assert_forced_default_R10: assert property (@(posedge clk) disable iff (rst)
                !enable |=> regs[k] == DEF_VAL);
            // R9: an honoured strobe copies the chain word.
            assert_strobe_copy_R9: assert property (@(posedge clk) disable iff (rst)
                (enable && strobe) |=> regs[k] == $past(src[k]));
        end
    endgenerate

endmodule

// File: rtl/word_loader.sv
module word_loader
    import word_loader_pkg::*;
#(
    parameter int CH = 16,
    localparam int W     = WORD_W,
    localparam int BUS_W = CH * W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             sclk_pol,
    input  logic [1:0]       chain_sel,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    input  logic             bc_enable,
    input  logic             dc_enable,
    input  logic             latch_stb,
    output logic [BUS_W-1:0] gs_latched,
    output logic [BUS_W-1:0] bc_latched,
    output logic [BUS_W-1:0] dc_latched
);
    logic       edge_act;
    chain_sel_e sel;
    word_t      chain_w [N_CHAINS][CH];
    word_t      bank_w  [N_CHAINS][CH];
    logic       bank_en [N_CHAINS];

    assign sel        = chain_sel_e'(chain_sel);
    assign bank_en[0] = 1'b1;
    assign bank_en[1] = bc_enable;
    assign bank_en[2] = dc_enable;

    word_loader_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk   (sclk),
        .pol    (sclk_pol),
        .active (edge_act)
    );

    generate
        for (genvar c = 0; c < N_CHAINS; c++) begin : g_chain
            logic picked;
            assign picked = (chain_sel == 2'(c));

            word_loader_chain #(.CH(CH)) u_chain (
                .clk   (clk),
                .rst   (rst),
                .shift (edge_act && picked),
                .din   (din),
                .words (chain_w[c])
            );

            word_loader_bank #(.CH(CH), .DEF_VAL(bank_default(c))) u_bank (
                .clk    (clk),
                .rst    (rst),
                .enable (bank_en[c]),
                .strobe (latch_stb && picked),
                .src    (chain_w[c]),
                .lat    (bank_w[c])
            );
        end

        for (genvar k = 0; k < CH; k++) begin : g_flat
            assign gs_latched[k*W +: W] = bank_w[0][k];
            assign bc_latched[k*W +: W] = bank_w[1][k];
            assign dc_latched[k*W +: W] = bank_w[2][k];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_GRAY:   dout = chain_w[0][CH-1];
            SEL_BRIGHT: dout = chain_w[1][CH-1];
            SEL_DOTCOR: dout = chain_w[2][CH-1];
            default:    dout = '0;
        endcase
    end

    // R6: the unused select code leaves the cascade output at zero.
    assert_unused_sel_zero_R6: assert property (@(posedge clk) disable iff (rst)
        chain_sel == 2'd3 |-> dout == '0);

    // R1: right after reset the cascade output is zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        $fell(rst) |-> dout == '0);

endmodule

// File: tb/test_word_loader.sv
module test_word_loader;
    localparam int CH = 4;
    localparam int W  = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sclk = 1'b0;
    logic            sclk_pol = 1'b1;
    logic [1:0]      chain_sel = 2'd0;
    logic [W-1:0]    din = '0;
    logic [W-1:0]    dout;
    logic            bc_enable = 1'b0;
    logic            dc_enable = 1'b0;
    logic            latch_stb = 1'b0;
    logic [CH*W-1:0] gs_latched, bc_latched, dc_latched;

    int    checks = 0;
    int    errors = 0;
    bit    live = 0;
    string phase = "R1 reset";

    logic [W-1:0] m_q   [3][$];
    logic [W-1:0] m_lat [3][CH];
    logic         m_prev;

    always #2.5 clk = ~clk;

    word_loader #(.CH(CH)) i_word_loader (
        .clk(clk), .rst(rst), .sclk(sclk), .sclk_pol(sclk_pol),
        .chain_sel(chain_sel), .din(din), .dout(dout),
        .bc_enable(bc_enable), .dc_enable(dc_enable), .latch_stb(latch_stb),
        .gs_latched(gs_latched), .bc_latched(bc_latched), .dc_latched(dc_latched)
    );

    function automatic logic [W-1:0] dflt(input int c);
        return (c == 0) ? '0 : '1;
    endfunction

    // Reference model, advanced on every rising clock edge.
    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 3; c++) begin
                m_q[c].delete();
                for (int k = 0; k < CH; k++) begin
                    m_q[c].push_back('0);
                    m_lat[c][k] = dflt(c);
                end
            end
        end else begin
            for (int c = 0; c < 3; c++) begin
                logic en;
                en = (c == 0) ? 1'b1 : (c == 1) ? bc_enable : dc_enable;
                if (!en) begin
                    for (int k = 0; k < CH; k++) m_lat[c][k] = dflt(c);
                end else if (latch_stb && chain_sel == 2'(c)) begin
                    for (int k = 0; k < CH; k++) m_lat[c][k] = m_q[c][k];
                end
            end
            if (sclk != m_prev && sclk == sclk_pol && chain_sel != 2'd3) begin
                m_q[chain_sel].push_front(din);
                void'(m_q[chain_sel].pop_back());
            end
        end
        m_prev = sclk;
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Comparison on every falling clock edge.
    always @(negedge clk) begin
        if (live) begin
            check({phase, " dout R4"}, dout, (chain_sel == 2'd3) ? '0 : m_q[chain_sel][CH-1]);
            for (int k = 0; k < CH; k++) begin
                check({phase, " gs bank R9"}, gs_latched[k*W +: W], m_lat[0][k]);
                check({phase, " bc bank R7"}, bc_latched[k*W +: W], m_lat[1][k]);
                check({phase, " dc bank R8"}, dc_latched[k*W +: W], m_lat[2][k]);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [W-1:0] w);
        din  = w;
        sclk = ~sclk_pol;
        step();
        sclk = sclk_pol;
        step();
    endtask

    task automatic strobe();
        latch_stb = 1'b1;
        step();
        latch_stb = 1'b0;
        step();
    endtask

    initial begin
        #(5 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        #1.5;
        check("R1 dout after reset", dout, '0);
        check("R1 gs word0", gs_latched[W-1:0], '0);
        check("R1 bc word0", bc_latched[W-1:0], '1);
        check("R1 dc word0", dc_latched[W-1:0], '1);
        live = 1;
        step();

        phase = "R2 rising grayscale";
        for (int i = 0; i < 6; i++) push(10'(37 * i + 5));
        phase = "R5 rising brightness";
        chain_sel = 2'd1;
        for (int i = 0; i < 4; i++) push(10'($urandom));
        phase = "R5 rising dotcor";
        chain_sel = 2'd2;
        for (int i = 0; i < 5; i++) push(10'($urandom));
        phase = "R4 select sweep";
        for (int s = 0; s < 4; s++) begin
            chain_sel = 2'(s);
            step();
        end
        phase = "R6 unused select";
        chain_sel = 2'd3;
        for (int i = 0; i < 3; i++) push(10'($urandom));
        check("R6 dout zero", dout, '0);

        phase = "R9 strobes enabled";
        bc_enable = 1'b1;
        dc_enable = 1'b1;
        step();
        for (int s = 0; s < 3; s++) begin
            chain_sel = 2'(s);
            strobe();
        end

        phase = "R7 brightness disabled";
        bc_enable = 1'b0;
        step();
        step();
        phase = "R10 strobe while disabled";
        chain_sel = 2'd1;
        strobe();
        dc_enable = 1'b0;
        chain_sel = 2'd2;
        step();
        phase = "R8 dotcor disabled";
        strobe();

        phase = "R3 falling grayscale";
        sclk_pol = 1'b0;
        chain_sel = 2'd0;
        step();
        for (int i = 0; i < 5; i++) push(10'($urandom));
        phase = "R3 falling brightness";
        chain_sel = 2'd1;
        for (int i = 0; i < 4; i++) push(10'($urandom));
        bc_enable = 1'b1;
        step();
        phase = "R9 strobe after falling";
        strobe();
        chain_sel = 2'd0;
        strobe();
        step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule